// File: doc/BRIEF.md
# Auto-Modifying Pointer Address Generator

This block turns the 9-bit source-operand field of a load/store instruction into an address. The field has two modes. In the first it carries an 8-bit immediate. In the second it names one of two 20-bit pointer registers and gives a signed 5-bit index. The index is scaled by the access size, so it counts in units of the data being moved. An optional writeback changes the pointer either before the access (pre-modify, where the new value is used) or after it (post-modify, where the old value is used).

The effective address and the mode flags are combinational from the field, the size select and the current pointer values. The pointers themselves change only at a clock edge. They change when the execute strobe is high and the field asks for an update, or when the direct write port loads a pointer. When both target the same pointer in the same cycle, the direct write wins. Memory access, instruction fetch and other addressing modes are handled elsewhere.

Top module: `ptr_agen`

## Requirements
- R1: After reset both pointers read zero.
- R2: When field bit 8 is 0, `imm_valid_o` is 1 and `ea_o` is bits 7:0 zero-extended to 20 bits. Neither pointer changes, even with `exec_i` high.
- R3: When field bit 8 is 1, the field is decoded as follows, and `imm_valid_o` is 0:
  - bit 7 selects the pointer (0 = A, 1 = B);
  - bit 6 is the update flag;
  - bit 5 is the post-modify flag;
  - bits 4:0 are a two's-complement index.
- R4: `size_i` sets the index scale:
  - 0 = byte, scale 1;
  - 1 = word, scale 2;
  - 2 = long, scale 4;
  - 3 = wide, scale 32.

  The offset is the index times the scale.
- R5: With update 0 and post 0, `ea_o` is the selected pointer plus the offset, and no pointer changes.
- R6: With update 1 and post 0 (pre-modify), `ea_o` is the pointer plus the offset, and the pointer takes that value at the next edge when `exec_i` is high.
- R7: With update 1 and post 1 (post-modify), `ea_o` is the unmodified pointer, and the pointer advances by the offset at the next edge when `exec_i` is high.
- R8: Address and pointer arithmetic wraps modulo 2^20.
- R9: With update 0 and post 1, `bad_enc_o` is 1, `ea_o` is the pointer plus the offset, and no pointer changes. In every other encoding `bad_enc_o` is 0.
- R10: When `pw_en_i` is high, the pointer chosen by `pw_sel_i` (0 = A, 1 = B) takes `pw_data_i` at the next edge, and this overrides an auto-update of that same pointer. An auto-update of the other pointer in the same cycle still happens.
- R11: When `exec_i` is low and `pw_en_i` is low, neither pointer changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opnd_i | input | 9 | Source-operand field |
| size_i | input | 2 | Access size code |
| exec_i | input | 1 | Execute strobe; allows pointer writeback |
| pw_en_i | input | 1 | Direct pointer write enable |
| pw_sel_i | input | 1 | Direct write target (0 = A, 1 = B) |
| pw_data_i | input | 20 | Direct write value |
| ea_o | output | 20 | Effective address, or the zero-extended immediate |
| imm_valid_o | output | 1 | Field is in immediate mode |
| bad_enc_o | output | 1 | Update 0 with post 1 was encoded |
| ptr_a_o | output | 20 | Current pointer A |
| ptr_b_o | output | 20 | Current pointer B |

## Verification
`ea_o`, `imm_valid_o` and `bad_enc_o` are due in the same cycle as the operand field. The bench therefore drives at a falling edge and samples them 1 ns later, before any rising edge. Pointer writebacks and direct writes land on the one rising edge after the stimulus. The bench reads the pointer outputs at the following falling edge, after deasserting the strobe, so each result is seen exactly one edge later. The sweep covers every size, pointer, mode bit pair and index value, and starts from bases chosen so that many sums cross the 2^20 boundary.

// File: rtl/ptr_agen_pkg.sv
// Shared constants and types for the pointer address generator.
// Assumes a fixed 9-bit operand field with a 5-bit index and 8-bit immediate.
package ptr_agen_pkg;
    localparam int OPND_W = 9;
    localparam int IDX_W  = 5;
    localparam int IMM_W  = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic             is_ptr;
        logic             sel;
        logic             upd;
        logic             post;
        logic [IDX_W-1:0] idx;
        logic [IMM_W-1:0] imm;
    } opnd_dec_t;
endpackage

// File: rtl/ptr_field_decode.sv
// Splits the operand field into its mode, pointer, update, post and index parts.
// Assumes: purely combinational; the immediate is bits 7:0 regardless of mode.
module ptr_field_decode
    import ptr_agen_pkg::*;
(
    input  logic [OPND_W-1:0] opnd,
    output opnd_dec_t         dec,
    output logic              bad_enc
);
    // Field split and illegal-combination detection
    always_comb begin
        dec.is_ptr = opnd[8];
        dec.sel    = opnd[7];
        dec.upd    = opnd[6];
        dec.post   = opnd[5];
        dec.idx    = opnd[IDX_W-1:0];
        dec.imm    = opnd[IMM_W-1:0];
        bad_enc    = opnd[8] & ~opnd[6] & opnd[5];
    end
endmodule

// File: rtl/ptr_offset_scale.sv
// Sign-extends the index and scales it by the access size using a shift.
// Assumes all scales are powers of two; result wraps at ADDR_W bits.
module ptr_offset_scale
    import ptr_agen_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [IDX_W-1:0]  idx,
    input  acc_size_e         size,
    output logic [ADDR_W-1:0] off
);
    localparam int EXT_W = ADDR_W - IDX_W;

    logic [ADDR_W-1:0] idx_ext;
    logic [2:0]        shamt;

    // Pick the shift amount for the access size
    always_comb begin
        unique case (size)
            SZ_BYTE: shamt = 3'd0;
            SZ_WORD: shamt = 3'd1;
            SZ_LONG: shamt = 3'd2;
            default: shamt = 3'd5;
        endcase
    end

    // Sign-extend and scale the index
    always_comb begin
        idx_ext = {{EXT_W{idx[IDX_W-1]}}, idx};
        off     = idx_ext << shamt;
    end
endmodule

// File: rtl/ptr_regfile.sv
// Holds the pointer registers. A direct write beats an auto-update of the same pointer.
// Assumes synchronous active-low reset to zero.
module ptr_regfile #(
    parameter int ADDR_W  = 20,
    parameter int NUM_PTR = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           auto_we,
    input  logic [$clog2(NUM_PTR)-1:0]     auto_sel,
    input  logic [ADDR_W-1:0]              auto_val,
    input  logic                           pw_en,
    input  logic [$clog2(NUM_PTR)-1:0]     pw_sel,
    input  logic [ADDR_W-1:0]              pw_data,
    output logic [NUM_PTR-1:0][ADDR_W-1:0] ptrs
);
    localparam int SEL_W = $clog2(NUM_PTR);

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
        // One pointer register with write-port priority
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptrs[g] <= '0;
            end else if (pw_en && pw_sel == SEL_W'(g)) begin
                ptrs[g] <= pw_data;
            end else if (auto_we && auto_sel == SEL_W'(g)) begin
                ptrs[g] <= auto_val;
            end
        end
    end
endmodule

// File: rtl/ptr_agen.sv
// Top of the pointer address generator: decode, scale, add, select and write back.
// Assumes the outputs are combinational from the field and the current pointers.
module ptr_agen
    import ptr_agen_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [8:0]        opnd_i,
    input  logic [1:0]        size_i,
    input  logic              exec_i,
    input  logic              pw_en_i,
    input  logic              pw_sel_i,
    input  logic [ADDR_W-1:0] pw_data_i,
    output logic [ADDR_W-1:0] ea_o,
    output logic              imm_valid_o,
    output logic              bad_enc_o,
    output logic [ADDR_W-1:0] ptr_a_o,
    output logic [ADDR_W-1:0] ptr_b_o
);
    localparam int NUM_PTR = 2;
    localparam int IMM_PAD = ADDR_W - IMM_W;

    opnd_dec_t                      dec;
    logic [ADDR_W-1:0]              off;
    logic [ADDR_W-1:0]              base;
    logic [ADDR_W-1:0]              sum;
    logic                           auto_we;
    logic [NUM_PTR-1:0][ADDR_W-1:0] ptrs;

    ptr_field_decode u_dec (
        .opnd    (opnd_i),
        .dec     (dec),
        .bad_enc (bad_enc_o)
    );

    ptr_offset_scale #(.ADDR_W(ADDR_W)) u_scale (
        .idx  (dec.idx),
        .size (acc_size_e'(size_i)),
        .off  (off)
    );

    // Address arithmetic and output selection
    always_comb begin
        base        = ptrs[dec.sel];
        sum         = base + off;
        imm_valid_o = ~dec.is_ptr;
        if (!dec.is_ptr)
            ea_o = {{IMM_PAD{1'b0}}, dec.imm};
        else if (dec.upd && dec.post)
            ea_o = base;
        else
            ea_o = sum;
        auto_we = exec_i & dec.is_ptr & dec.upd;
    end

    ptr_regfile #(.ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .auto_we  (auto_we),
        .auto_sel (dec.sel),
        .auto_val (sum),
        .pw_en    (pw_en_i),
        .pw_sel   (pw_sel_i),
        .pw_data  (pw_data_i),
        .ptrs     (ptrs)
    );

    assign ptr_a_o = ptrs[0];
    assign ptr_b_o = ptrs[1];
endmodule

// File: rtl/ptr_agen_chk.sv
// Property checker for ptr_agen, bound to every instance of it.
module ptr_agen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [8:0]  opnd_i,
    input logic [1:0]  size_i,
    input logic        exec_i,
    input logic        pw_en_i,
    input logic        pw_sel_i,
    input logic [19:0] pw_data_i,
    input logic [19:0] ea_o,
    input logic        imm_valid_o,
    input logic        bad_enc_o,
    input logic [19:0] ptr_a_o,
    input logic [19:0] ptr_b_o
);
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec_i && !pw_en_i) |=> ($stable(ptr_a_o) && $stable(ptr_b_o)));

    p_imm_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!opnd_i[8]) |-> (imm_valid_o && ea_o == {12'd0, opnd_i[7:0]}));

    p_imm_no_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!opnd_i[8] && !pw_en_i) |=> ($stable(ptr_a_o) && $stable(ptr_b_o)));

    p_bad_only_ptr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bad_enc_o |-> (opnd_i[8] && !imm_valid_o));

    p_post_ea_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (opnd_i[8:5] == 4'b1011) |-> (ea_o == ptr_a_o));

    p_pre_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && opnd_i[8:5] == 4'b1010 && !(pw_en_i && !pw_sel_i))
        |=> (ptr_a_o == $past(ea_o)));

    p_wide_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && opnd_i == 9'b111100001 && size_i == 2'd3 && !(pw_en_i && pw_sel_i))
        |=> (ptr_b_o == $past(ptr_b_o) + 20'd32));

    p_direct_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_en_i && !pw_sel_i) |=> (ptr_a_o == $past(pw_data_i)));
endmodule

bind ptr_agen ptr_agen_chk u_chk (.*);

// File: tb/tb_ptr_agen.sv
module tb_ptr_agen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  opnd_i = '0;
    logic [1:0]  size_i = '0;
    logic        exec_i = 1'b0;
    logic        pw_en_i = 1'b0;
    logic        pw_sel_i = 1'b0;
    logic [19:0] pw_data_i = '0;
    logic [19:0] ea_o;
    logic        imm_valid_o;
    logic        bad_enc_o;
    logic [19:0] ptr_a_o;
    logic [19:0] ptr_b_o;

    int nvec = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ptr_agen dut (
        .clk(clk), .rst_n(rst_n), .opnd_i(opnd_i), .size_i(size_i),
        .exec_i(exec_i), .pw_en_i(pw_en_i), .pw_sel_i(pw_sel_i),
        .pw_data_i(pw_data_i), .ea_o(ea_o), .imm_valid_o(imm_valid_o),
        .bad_enc_o(bad_enc_o), .ptr_a_o(ptr_a_o), .ptr_b_o(ptr_b_o)
    );

    task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int scale_of(input int sz);
        case (sz)
            0: return 1;
            1: return 2;
            2: return 4;
            default: return 32;
        endcase
    endfunction

    function automatic logic [19:0] add_off(input logic [19:0] p, input int idx, input int sz);
        int si;
        int s;
        si = (idx >= 16) ? idx - 32 : idx;
        s  = int'(p) + si * scale_of(sz);
        return 20'(s);
    endfunction

    function automatic logic [19:0] rd_ptr(input bit sel);
        return sel ? ptr_b_o : ptr_a_o;
    endfunction

    task automatic load_ptrs(input logic [19:0] a, input logic [19:0] b);
        @(negedge clk);
        exec_i = 0; pw_en_i = 1; pw_sel_i = 0; pw_data_i = a;
        @(negedge clk);
        pw_sel_i = 1; pw_data_i = b;
        @(negedge clk);
        pw_en_i = 0;
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        logic [19:0] base, other, exp_ea, exp_new;
        int count;
        count = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 ptr A reset", ptr_a_o, 20'h0);
        chk("R1 ptr B reset", ptr_b_o, 20'h0);

        // Full sweep: size x pointer x (upd,post) x index
        for (int sz = 0; sz < 4; sz++) begin
            for (int sel = 0; sel < 2; sel++) begin
                for (int mode = 0; mode < 4; mode++) begin
                    for (int idx = 0; idx < 32; idx++) begin
                        bit upd, post;
                        upd  = mode[1];
                        post = mode[0];
                        base  = 20'(32'hFFFC0 + count * 7919);
                        other = ~base;
                        count++;
                        if (sel == 0) load_ptrs(base, other);
                        else          load_ptrs(other, base);
                        chk("R10 direct load", rd_ptr(sel[0]), base);
                        opnd_i = {1'b1, sel[0], upd, post, 5'(idx)};
                        size_i = 2'(sz);
                        exec_i = 1;
                        #1;
                        exp_new = add_off(base, idx, sz);
                        exp_ea  = (upd && post) ? base : exp_new;
                        if (upd && post)      chk("R7 post ea", ea_o, exp_ea);
                        else if (upd)         chk("R6/R4/R8 pre ea", ea_o, exp_ea);
                        else if (post)        chk("R9 offset ea", ea_o, exp_ea);
                        else                  chk("R5/R3 offset ea", ea_o, exp_ea);
                        chk("R9 bad flag", 20'(bad_enc_o), 20'(!upd && post));
                        chk("R3 imm flag low", 20'(imm_valid_o), 20'h0);
                        @(negedge clk);
                        exec_i = 0;
                        chk(upd ? "R6/R7 writeback" : "R5/R9 no change",
                            rd_ptr(sel[0]), upd ? exp_new : base);
                        chk("R3 other ptr untouched", rd_ptr(!sel[0]), other);
                    end
                end
            end
        end

        // Immediate mode sweep with execute high
        load_ptrs(20'h12345, 20'hABCDE);
        for (int v = 0; v < 256; v++) begin
            opnd_i = {1'b0, 8'(v)};
            size_i = 2'(v % 4);
            exec_i = 1;
            #1;
            chk("R2 imm valid", 20'(imm_valid_o), 20'h1);
            chk("R2 imm ea", ea_o, 20'(v));
            chk("R2 imm not bad", 20'(bad_enc_o), 20'h0);
            @(negedge clk);
            exec_i = 0;
            chk("R2 ptr A held", ptr_a_o, 20'h12345);
            chk("R2 ptr B held", ptr_b_o, 20'hABCDE);
        end

        // Execute low: update encodings must not touch pointers
        for (int v = 0; v < 16; v++) begin
            @(negedge clk);
            opnd_i = {1'b1, v[0], 1'b1, v[1], 5'(v + 1)};
            size_i = 2'(v % 4);
            exec_i = 0;
            @(negedge clk);
            chk("R11 A held exec low", ptr_a_o, 20'h12345);
            chk("R11 B held exec low", ptr_b_o, 20'hABCDE);
        end

        // Wrap: pre-increment byte from all-ones
        load_ptrs(20'hFFFFF, 20'h00000);
        opnd_i = 9'b101000001; size_i = 0; exec_i = 1;
        #1;
        chk("R8 wrap ea", ea_o, 20'h00000);
        @(negedge clk);
        exec_i = 0;
        chk("R8 wrap ptr", ptr_a_o, 20'h00000);
        // Wrap downward: post-decrement wide from zero on B
        opnd_i = 9'b111111111; size_i = 3; exec_i = 1;
        #1;
        chk("R8 post ea B", ea_o, 20'h00000);
        @(negedge clk);
        exec_i = 0;
        chk("R8 wrap down B", ptr_b_o, 20'hFFFE0);

        // Priority: direct write to A with pre-modify of A
        load_ptrs(20'h00100, 20'h00200);
        opnd_i = 9'b101000001; size_i = 2; exec_i = 1;
        pw_en_i = 1; pw_sel_i = 0; pw_data_i = 20'h55555;
        @(negedge clk);
        exec_i = 0; pw_en_i = 0;
        chk("R10 direct beats auto", ptr_a_o, 20'h55555);
        chk("R10 B untouched", ptr_b_o, 20'h00200);

        // Direct write to B while A auto-updates
        opnd_i = 9'b101100001; size_i = 1; exec_i = 1;
        pw_en_i = 1; pw_sel_i = 1; pw_data_i = 20'h0AAAA;
        @(negedge clk);
        exec_i = 0; pw_en_i = 0;
        chk("R10 A auto still applied", ptr_a_o, 20'h55557);
        chk("R10 B direct", ptr_b_o, 20'h0AAAA);

        // Reset mid-run clears pointers
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        chk("R1 A after reset", ptr_a_o, 20'h0);
        chk("R1 B after reset", ptr_b_o, 20'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule